// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block produces the serial clock for an I2C master from a fast module clock. A programmable prescaler first divides the module clock into a slower tick. The block then counts ticks for the low half of each SCL period and again for the high half, so the two halves are set separately. Each half is the programmed count plus a fixed extra term. That term depends on the prescaler setting: 7 ticks for a prescaler of 0, 6 ticks for a prescaler of 1, and 5 ticks for any larger prescaler. The tick is meant to run somewhere around 7 to 12 MHz, and software chooses the prescaler to get there.

The controller writes the prescaler and the two half-period counts while `run` is low. Taking `run` high starts the clock with a low phase. SCL is an open-drain line, so the block only pulls it low. At the end of each low phase it lets the line go and waits until the line is seen high through a synchronizer, which lets a slave stretch the clock. Only then does the high count start. Two strobes go to the bit engine. One marks the first cycle of each low phase, where SDA may change. The other marks the middle of each high phase, where SDA is sampled.

Reset is asynchronous and active low, and its release is synchronised internally over two module clock cycles.

Top module: `i2c_scl_gen`

## Requirements
- R1: While `rst_n` is low, or `run` has been low at the previous clock edge, `scl_drive_low`, `strb_sample` and `strb_change` are all 0.
- R2: The low phase lasts exactly (max(low_cnt,1) + d) * (psc + 1) module clock cycles. During it `scl_drive_low` is 1.
- R3: If no slave stretches the clock, SCL stays released for (SYNC_STAGES + 1) + (max(high_cnt,1) + d) * (psc + 1) cycles. SYNC_STAGES defaults to 2.
- R4: The delay term d is 7 when psc = 0, 6 when psc = 1 and 5 when psc >= 2.
- R5: A `low_cnt` or `high_cnt` value of 0 gives the same timing as a value of 1.
- R6: The high count starts only once `scl_in` has been seen high through the SYNC_STAGES-flop synchronizer. While the line is held low after release, no high-phase counting and no sample strobe occur.
- R7: `strb_sample` is a one-cycle pulse, given once in each high phase. It comes at offset (SYNC_STAGES + 1) + floor(hlen/2) * (psc + 1) from the first released cycle, where hlen = max(high_cnt,1) + d.
- R8: `strb_change` is 1 in the first cycle of every low phase and in no other cycle.
- R9: The prescaler and both counts are captured only while `run` is low. Changes made while `run` is high do not change the timing until `run` has been low again.
- R10: Dropping `run` releases SCL on the next cycle. Raising it again starts a new low phase, with `strb_change` set, on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | 0 holds the generator idle and open for configuration; 1 runs it |
| psc | input | PSC_W (8) | Prescaler value; the tick period is psc+1 module clocks |
| low_cnt | input | CNT_W (16) | Low half-period count, in ticks, before the delay term is added |
| high_cnt | input | CNT_W (16) | High half-period count, in ticks, before the delay term is added |
| scl_in | input | 1 | Level seen on the SCL line, used to detect stretching |
| scl_drive_low | output | 1 | 1 pulls SCL low; 0 releases it |
| strb_sample | output | 1 | Pulse in the middle of the high phase |
| strb_change | output | 1 | Pulse in the first cycle of the low phase |

## Verification
The assertions assume that `run` and the configuration inputs are driven from time zero and change only away from the clock edge. They also assume `scl_in` follows the wired-AND of this block's drive and any stretching slave, and that every low phase is longer than the synchronizer. The smallest low phase is 6 ticks, so that always holds. The bench models SCL as an open-drain line that is released unless this block or the stretch model pulls it low. It changes the configuration or `run` only at falling clock edges, and stretches only in the released phase, starting from the low phase before it.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;

  // Fixed extra ticks per half period, chosen by the prescaler value
  function automatic logic [2:0] delay_term(input logic is_zero, input logic is_one);
    if (is_zero)     delay_term = 3'd7;
    else if (is_one) delay_term = 3'd6;
    else             delay_term = 3'd5;
  endfunction

endpackage

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold
  import i2c_scl_pkg::*;
#(
  parameter int PSC_W = 8,
  parameter int CNT_W = 16,
  localparam int LEN_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  output logic [PSC_W-1:0] cfg_psc,
  output logic [LEN_W-1:0] cfg_low_len,
  output logic [LEN_W-1:0] cfg_high_len,
  output logic [LEN_W-1:0] cfg_half_len
);

  logic [2:0]       dly;
  logic [CNT_W-1:0] low_eff, high_eff;
  logic [LEN_W-1:0] low_len_d, high_len_d;
  logic             load_en;

  // Lengths, with the delay term, are computed here so the counters compare against a register
  always_comb begin
    dly        = delay_term(psc == '0, psc == PSC_W'(1));
    low_eff    = (low_cnt  == '0) ? CNT_W'(1) : low_cnt;
    high_eff   = (high_cnt == '0) ? CNT_W'(1) : high_cnt;
    low_len_d  = {1'b0, low_eff}  + LEN_W'(dly);
    high_len_d = {1'b0, high_eff} + LEN_W'(dly);
    load_en    = ~run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_psc      <= '0;
      cfg_low_len  <= LEN_W'(8);
      cfg_high_len <= LEN_W'(8);
      cfg_half_len <= LEN_W'(4);
    end else if (load_en) begin
      cfg_psc      <= psc;
      cfg_low_len  <= low_len_d;
      cfg_high_len <= high_len_d;
      cfg_half_len <= high_len_d >> 1;
    end
  end

endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] limit,
  output logic             tick
);

  logic [PSC_W-1:0] pc_q, pc_d;

  always_comb begin
    tick = run & (pc_q == limit);
    if (!run || restart || tick) pc_d = '0;
    else                         pc_d = pc_q + PSC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

endmodule

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b1;
          else        stage_q[i] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b1;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/scl_phase_ctl.sv
module scl_phase_ctl
  import i2c_scl_pkg::*;
#(
  parameter int LEN_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             scl_hi,
  input  logic [LEN_W-1:0] low_len,
  input  logic [LEN_W-1:0] high_len,
  input  logic [LEN_W-1:0] half_len,
  output scl_phase_e       phase,
  output logic             restart,
  output logic             drive_low,
  output logic             strb_sample,
  output logic             strb_change
);

  scl_phase_e       phase_q, phase_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             sample_d, change_d;
  logic             low_last, high_last, high_mid;

  always_comb begin
    low_last  = (cnt_q == low_len  - LEN_W'(1));
    high_last = (cnt_q == high_len - LEN_W'(1));
    high_mid  = (cnt_q == half_len - LEN_W'(1));
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    restart   = 1'b0;
    sample_d  = 1'b0;
    change_d  = 1'b0;
    if (!run) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_d  = PH_LOW;
          cnt_d    = '0;
          restart  = 1'b1;
          change_d = 1'b1;
        end
        PH_LOW: begin
          if (tick) begin
            if (low_last) begin
              phase_d = PH_WAIT;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + LEN_W'(1);
            end
          end
        end
        PH_WAIT: begin
          if (scl_hi) begin
            phase_d = PH_HIGH;
            cnt_d   = '0;
            restart = 1'b1;
          end
        end
        PH_HIGH: begin
          if (tick) begin
            sample_d = high_mid;
            if (high_last) begin
              phase_d  = PH_LOW;
              cnt_d    = '0;
              restart  = 1'b1;
              change_d = 1'b1;
            end else begin
              cnt_d = cnt_q + LEN_W'(1);
            end
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      cnt_q       <= '0;
      strb_sample <= 1'b0;
      strb_change <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      cnt_q       <= cnt_d;
      strb_sample <= sample_d;
      strb_change <= change_d;
    end
  end

  assign phase     = phase_q;
  assign drive_low = (phase_q == PH_LOW);

endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
  import i2c_scl_pkg::*;
#(
  parameter int PSC_W       = 8,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             strb_sample,
  output logic             strb_change
);

  localparam int LEN_W = CNT_W + 1;

  logic [1:0]       rst_pipe;
  logic             rst_i_n;
  logic [PSC_W-1:0] cfg_psc;
  logic [LEN_W-1:0] cfg_low_len, cfg_high_len, cfg_half_len;
  logic             tick, restart, scl_hi;
  scl_phase_e       phase;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  scl_cfg_hold #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_i_n), .run(run), .psc(psc),
    .low_cnt(low_cnt), .high_cnt(high_cnt),
    .cfg_psc(cfg_psc), .cfg_low_len(cfg_low_len),
    .cfg_high_len(cfg_high_len), .cfg_half_len(cfg_half_len)
  );

  scl_tick_gen #(.PSC_W(PSC_W)) u_tick (
    .clk(clk), .rst_n(rst_i_n), .run(run), .restart(restart),
    .limit(cfg_psc), .tick(tick)
  );

  scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .din(scl_in), .dout(scl_hi)
  );

  scl_phase_ctl #(.LEN_W(LEN_W)) u_phase (
    .clk(clk), .rst_n(rst_i_n), .run(run), .tick(tick), .scl_hi(scl_hi),
    .low_len(cfg_low_len), .high_len(cfg_high_len), .half_len(cfg_half_len),
    .phase(phase), .restart(restart), .drive_low(scl_drive_low),
    .strb_sample(strb_sample), .strb_change(strb_change)
  );

endmodule

// File: rtl/i2c_scl_gen_chk.sv
module i2c_scl_gen_chk
  import i2c_scl_pkg::*;
#(
  parameter int LEN_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             scl_drive_low,
  input logic             strb_sample,
  input logic             strb_change,
  input scl_phase_e       phase,
  input logic             scl_hi,
  input logic [LEN_W-1:0] cfg_low_len,
  input logic [LEN_W-1:0] cfg_high_len
);

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!scl_drive_low && !strb_sample && !strb_change)) else $error("idle"); // R1

  AST_LOW_ENTRY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> strb_change) else $error("change missing"); // R8

  AST_CHANGE_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    strb_change |-> scl_drive_low) else $error("change outside low"); // R8

  AST_SAMPLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    strb_sample |-> (!scl_drive_low && phase == PH_HIGH)) else $error("sample misplaced"); // R7

  AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    strb_sample |=> !strb_sample) else $error("sample width"); // R7

  AST_NO_HIGH_WITHOUT_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT && !scl_hi) |=> (phase != PH_HIGH)) else $error("stretch ignored"); // R6

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ($stable(cfg_low_len) && $stable(cfg_high_len))) else $error("cfg moved"); // R9

endmodule

bind i2c_scl_gen i2c_scl_gen_chk #(.LEN_W(CNT_W + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .scl_drive_low(scl_drive_low),
  .strb_sample(strb_sample), .strb_change(strb_change), .phase(phase),
  .scl_hi(scl_hi), .cfg_low_len(cfg_low_len), .cfg_high_len(cfg_high_len)
);

// File: tb/i2c_scl_gen_bench.sv
`timescale 1ns/1ps
module i2c_scl_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n, run, stretch;
  logic [7:0]  psc;
  logic [15:0] low_cnt, high_cnt;
  logic        scl_in, scl_drive_low, strb_sample, strb_change;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  // Open-drain SCL: low when this block or the stretching slave pulls it
  assign scl_in = ~(scl_drive_low | stretch);

  i2c_scl_gen u_i2c_scl_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .psc(psc), .low_cnt(low_cnt),
    .high_cnt(high_cnt), .scl_in(scl_in), .scl_drive_low(scl_drive_low),
    .strb_sample(strb_sample), .strb_change(strb_change)
  );

  // {psc, low, high, low cycles, released cycles, sample offset}
  localparam int NV = 6;
  localparam int VEC [NV][6] = '{
    '{0, 3,  2, 10,  12,  7},
    '{1, 4,  6, 20,  27, 15},
    '{2, 1,  3, 18,  27, 15},
    '{4, 0,  0, 30,  33, 18},
    '{3, 10, 2, 60,  31, 15},
    '{7, 2,  9, 56, 115, 59}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_cfg(input int v);
    run = 1'b0;
    psc = 8'(VEC[v][0]); low_cnt = 16'(VEC[v][1]); high_cnt = 16'(VEC[v][2]);
    repeat (4) @(negedge clk);
  endtask

  task automatic measure(output int lowc, output int highc, output int sofs,
                         output int nsamp, output int chg_ok);
    while (!scl_drive_low) @(negedge clk);
    while (scl_drive_low) @(negedge clk);
    highc = 0; sofs = -1; nsamp = 0;
    while (!scl_drive_low) begin
      if (strb_sample) begin sofs = highc; nsamp++; end
      highc++;
      @(negedge clk);
    end
    chg_ok = int'(strb_change);
    lowc = 0;
    while (scl_drive_low) begin
      if (strb_change && lowc != 0) chg_ok = 0;
      lowc++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lowc, highc, sofs, nsamp, chg, rel, bad;
    rst_n = 1'b0; run = 1'b0; stretch = 1'b0;
    psc = '0; low_cnt = '0; high_cnt = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset drive", int'(scl_drive_low), 0);
    chk("R1 reset strobes", int'(strb_sample | strb_change), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 idle after reset", int'(scl_drive_low | strb_sample | strb_change), 0);

    // R2 R3 R4 R5 R7 R8: table walk over delay-term classes and zero counts
    for (int v = 0; v < NV; v++) begin
      load_cfg(v);
      run = 1'b1;
      measure(lowc, highc, sofs, nsamp, chg);
      chk($sformatf("R2/R4/R5 vec%0d low", v), lowc, VEC[v][3]);
      chk($sformatf("R3/R4/R5 vec%0d released", v), highc, VEC[v][4]);
      chk($sformatf("R7 vec%0d sample offset", v), sofs, VEC[v][5]);
      chk($sformatf("R7 vec%0d sample count", v), nsamp, 1);
      chk($sformatf("R8 vec%0d change strobe", v), chg, 1);
    end

    // R6: slave stretches 20 cycles after release
    load_cfg(0);
    run = 1'b1;
    while (!scl_drive_low) @(negedge clk);
    stretch = 1'b1;
    while (scl_drive_low) @(negedge clk);
    rel = 0; bad = 0; sofs = -1;
    repeat (20) begin
      if (strb_sample) bad++;
      rel++;
      @(negedge clk);
    end
    stretch = 1'b0;
    while (!scl_drive_low) begin
      if (strb_sample) sofs = rel;
      rel++;
      @(negedge clk);
    end
    chk("R6 no sample while stretched", bad, 0);
    chk("R6 stretched released length", rel, 32);
    chk("R6 sample after stretch", sofs, 27);

    // R9: changes while running are ignored until run drops
    load_cfg(1);
    run = 1'b1;
    while (!scl_drive_low) @(negedge clk);
    psc = 8'(VEC[5][0]); low_cnt = 16'(VEC[5][1]); high_cnt = 16'(VEC[5][2]);
    measure(lowc, highc, sofs, nsamp, chg);
    chk("R9 low unchanged while running", lowc, VEC[1][3]);
    chk("R9 released unchanged while running", highc, VEC[1][4]);
    run = 1'b0;
    repeat (4) @(negedge clk);
    run = 1'b1;
    measure(lowc, highc, sofs, nsamp, chg);
    chk("R9 new low after reload", lowc, VEC[5][3]);
    chk("R9 new released after reload", highc, VEC[5][4]);

    // R10: drop run in mid low phase, then restart
    load_cfg(0);
    run = 1'b1;
    while (!scl_drive_low) @(negedge clk);
    repeat (3) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    chk("R10 released after run drop", int'(scl_drive_low), 0);
    bad = 0;
    repeat (10) begin
      if (scl_drive_low || strb_sample || strb_change) bad++;
      @(negedge clk);
    end
    chk("R10/R1 stays idle", bad, 0);
    run = 1'b1;
    @(negedge clk);
    chk("R10 low on restart", int'(scl_drive_low), 1);
    chk("R10/R8 change on restart", int'(strb_change), 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule